// File: doc/BRIEF.md
# Five-Port Dimension-Order Mesh Router

This block moves packets of flits between the five sides of one node in a two-dimensional mesh: the four neighbour links (north, east, south, west) and the local attachment point. Every arriving flit is written into a queue for its input side. The first flit of a packet carries the destination column and row. From these the router chooses an exit side. It closes the column gap first, then the row gap. When both match the node's own coordinates, which are fixed parameters, the packet is delivered to the local side. Body and final flits travel on the exit chosen for their packet's first flit.

Each exit side has its own rotating-priority arbiter. After an exit accepts the first flit of a multi-flit packet, no other input can use that exit until the packet's final flit has gone. Traffic is paced by credits. Each exit holds a counter of free slots in the neighbour's queue and sends only while that counter is above zero. Each input returns one credit pulse upstream for every flit that leaves its queue.

Side numbering is fixed: 0 local, 1 north, 2 east, 3 south, 4 west. The column grows toward east and the row grows toward north.

Top module: `mesh_xy_router`

## Requirements
- R1: During and right after reset, every `out_valid` and `in_credit` bit is low, and every exit's credit counter holds CREDITS.
- R2: A first flit whose destination column is above MY_X leaves on side 2. One whose column is below MY_X leaves on side 4. The row does not affect either case.
- R3: A first flit whose column equals MY_X leaves on side 1 when its row is above MY_Y, and on side 3 when its row is below MY_Y.
- R4: A first flit whose column equals MY_X and whose row equals MY_Y leaves on side 0.
- R5: The destination column is read from flit bits [COORD_W-1:0] and the row from bits [2*COORD_W-1:COORD_W], on the first flit only. Body and final flits follow their first flit's exit whatever their data bits hold.
- R6: A flit presented in the cycle before rising edge E, to an idle exit that holds a credit, is visible on that exit after edge E+1. Its data, first-flit marker and final-flit marker are unchanged.
- R7: With no credits coming back, an exit sends exactly CREDITS flits and then stops. Each returned credit pulse allows exactly one more flit.
- R8: Each flit that leaves an input queue gives exactly one single-cycle `in_credit` pulse on that input. The pulse falls in the same cycle as the flit's appearance on its exit.
- R9: When several inputs present first flits for the same unlocked exit, grants go in rotating order. The search starts at the input just after the one granted last.
- R10: Once an exit sends the first flit of a multi-flit packet, it carries only that input's flits until the final flit has gone.
- R11: A flit with both markers set is a whole packet. Its exit can serve another input on the very next cycle.
- R12: Flits waiting for credits stay queued and leave later, in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 5 | Flit present on each input side |
| in_head | input | 5 | First-flit marker per input side |
| in_tail | input | 5 | Final-flit marker per input side |
| in_data | input | 5 x DATA_W | Flit payload per input side |
| in_credit | output | 5 | One-cycle credit pulse back to each upstream sender |
| out_valid | output | 5 | Flit present on each exit side |
| out_head | output | 5 | First-flit marker per exit side |
| out_tail | output | 5 | Final-flit marker per exit side |
| out_data | output | 5 x DATA_W | Flit payload per exit side |
| out_credit | input | 5 | Credit pulse returned by each downstream receiver |

## Verification
A flit driven before rising edge E is written into its queue at E. It is registered onto its exit at E+1, and its credit pulse is registered at that same edge. The bench drives inputs on falling edges. It checks the exact cycle, the falling edge after E+1, together with the quiet cycles on either side of it. For ordering, rotation and credit stalls, a falling-edge monitor records every exit flit with its cycle number. The checks then wait a fixed margin after the last expected event and compare contents, order, counts and cycle gaps against values worked out from the requirements. A returned credit is counted at the next rising edge and enables a send one edge later, so credit checks wait several cycles before they look.

// File: rtl/mesh_xy_router.sv
module mesh_xy_router #(
  parameter int DATA_W     = 16,
  parameter int COORD_W    = 3,
  parameter int MY_X       = 2,
  parameter int MY_Y       = 2,
  parameter int FIFO_DEPTH = 4,
  parameter int CREDITS    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [4:0]             in_valid,
  input  logic [4:0]             in_head,
  input  logic [4:0]             in_tail,
  input  logic [4:0][DATA_W-1:0] in_data,
  output logic [4:0]             in_credit,
  output logic [4:0]             out_valid,
  output logic [4:0]             out_head,
  output logic [4:0]             out_tail,
  output logic [4:0][DATA_W-1:0] out_data,
  input  logic [4:0]             out_credit
);
  localparam int NP = 5;
  localparam int FW = DATA_W + 2;
  localparam int AW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int KW = $clog2(CREDITS + 1);
  localparam logic [2:0] P_LOCAL = 3'd0;
  localparam logic [2:0] P_NORTH = 3'd1;
  localparam logic [2:0] P_EAST  = 3'd2;
  localparam logic [2:0] P_SOUTH = 3'd3;
  localparam logic [2:0] P_WEST  = 3'd4;

  function automatic logic [2:0] xy_route(input logic [COORD_W-1:0] dx,
                                          input logic [COORD_W-1:0] dy);
    if (int'(dx) > MY_X) return P_EAST;
    if (int'(dx) < MY_X) return P_WEST;
    if (int'(dy) > MY_Y) return P_NORTH;
    if (int'(dy) < MY_Y) return P_SOUTH;
    return P_LOCAL;
  endfunction

  function automatic logic [2:0] rot(input logic [2:0] base, input int k);
    int s;
    s = int'(base) + k;
    if (s >= NP) s = s - NP;
    return 3'(s);
  endfunction

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (int'(p) == FIFO_DEPTH - 1) ? '0 : p + AW'(1);
  endfunction

  logic [FW-1:0] mem [NP][FIFO_DEPTH];
  logic [AW-1:0] wp [NP];
  logic [AW-1:0] rp [NP];
  logic [CW-1:0] cnt [NP];
  logic [2:0]    route_q [NP];
  logic [2:0]    dir [NP];
  logic [2:0]    owner_q [NP];
  logic [2:0]    ptr_q [NP];
  logic [2:0]    sel [NP];
  logic [KW-1:0] cred_q [NP];
  logic [FW-1:0] front [NP];
  logic [NP-1:0] nonempty, fhead, ftail, fire, pop, lock_q;
  logic [NP-1:0][DATA_W-1:0] fdata;
  logic [NP-1:0][NP-1:0]     hit;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      front[i]    = mem[i][rp[i]];
      nonempty[i] = cnt[i] != '0;
      fhead[i]    = front[i][FW-1];
      ftail[i]    = front[i][FW-2];
      fdata[i]    = front[i][DATA_W-1:0];
      dir[i]      = fhead[i] ? xy_route(front[i][COORD_W-1:0], front[i][2*COORD_W-1:COORD_W])
                             : route_q[i];
    end
  end

  always_comb begin
    fire = '0;
    pop  = '0;
    hit  = '0;
    for (int o = 0; o < NP; o++) begin
      sel[o] = P_LOCAL;
      if (cred_q[o] != '0) begin
        if (lock_q[o]) begin
          if (nonempty[owner_q[o]] && dir[owner_q[o]] == 3'(o)) begin
            fire[o] = 1'b1;
            sel[o]  = owner_q[o];
          end
        end else begin
          for (int k = 0; k < NP; k++) begin
            if (!fire[o] && nonempty[rot(ptr_q[o], k)] && fhead[rot(ptr_q[o], k)]
                && dir[rot(ptr_q[o], k)] == 3'(o)) begin
              fire[o] = 1'b1;
              sel[o]  = rot(ptr_q[o], k);
            end
          end
        end
      end
      if (fire[o]) begin
        pop[sel[o]]    = 1'b1;
        hit[sel[o]][o] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NP; i++)
      if (in_valid[i]) mem[i][wp[i]] <= {in_head[i], in_tail[i], in_data[i]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin
        wp[i]      <= '0;
        rp[i]      <= '0;
        cnt[i]     <= '0;
        route_q[i] <= P_LOCAL;
      end
      in_credit <= '0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (in_valid[i]) wp[i] <= adv(wp[i]);
        if (pop[i]) rp[i] <= adv(rp[i]);
        case ({in_valid[i], pop[i]})
          2'b10:   cnt[i] <= cnt[i] + CW'(1);
          2'b01:   cnt[i] <= cnt[i] - CW'(1);
          default: cnt[i] <= cnt[i];
        endcase
        if (pop[i] && fhead[i]) route_q[i] <= dir[i];
      end
      in_credit <= pop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= '0;
      out_head  <= '0;
      out_tail  <= '0;
      out_data  <= '0;
      lock_q    <= '0;
      for (int o = 0; o < NP; o++) begin
        owner_q[o] <= P_LOCAL;
        ptr_q[o]   <= P_LOCAL;
        cred_q[o]  <= KW'(CREDITS);
      end
    end else begin
      out_valid <= fire;
      for (int o = 0; o < NP; o++) begin
        if (fire[o]) begin
          out_data[o] <= fdata[sel[o]];
          out_head[o] <= fhead[sel[o]];
          out_tail[o] <= ftail[sel[o]];
          if (ftail[sel[o]]) begin
            lock_q[o] <= 1'b0;
          end else if (fhead[sel[o]]) begin
            lock_q[o]  <= 1'b1;
            owner_q[o] <= sel[o];
          end
          if (!lock_q[o]) ptr_q[o] <= rot(sel[o], 1);
        end
        case ({fire[o], out_credit[o]})
          2'b10:   cred_q[o] <= cred_q[o] - KW'(1);
          2'b01:   cred_q[o] <= cred_q[o] + KW'(1);
          default: cred_q[o] <= cred_q[o];
        endcase
      end
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_chk
    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid[g] |-> (int'(cnt[g]) < FIFO_DEPTH || pop[g])); // R12
    AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cred_q[g]) <= CREDITS); // R7
    AST_NO_SEND_DRY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[g] |-> $past(cred_q[g]) != '0); // R7
    AST_CREDIT_FROM_POP: assert property (@(posedge clk) disable iff (!rst_n)
      in_credit[g] |-> $past(cnt[g]) != '0); // R8
    AST_ONE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hit[g]) <= 1); // R5
  end

  AST_EAST_X: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid[P_EAST] && out_head[P_EAST]) |-> int'(out_data[P_EAST][COORD_W-1:0]) > MY_X); // R2
  AST_WEST_X: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid[P_WEST] && out_head[P_WEST]) |-> int'(out_data[P_WEST][COORD_W-1:0]) < MY_X); // R2
  AST_NORTH_Y: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid[P_NORTH] && out_head[P_NORTH]) |->
      (int'(out_data[P_NORTH][COORD_W-1:0]) == MY_X &&
       int'(out_data[P_NORTH][2*COORD_W-1:COORD_W]) > MY_Y)); // R3
  AST_SOUTH_Y: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid[P_SOUTH] && out_head[P_SOUTH]) |->
      (int'(out_data[P_SOUTH][COORD_W-1:0]) == MY_X &&
       int'(out_data[P_SOUTH][2*COORD_W-1:COORD_W]) < MY_Y)); // R3
  AST_LOCAL_EJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid[P_LOCAL] && out_head[P_LOCAL]) |->
      (int'(out_data[P_LOCAL][COORD_W-1:0]) == MY_X &&
       int'(out_data[P_LOCAL][2*COORD_W-1:COORD_W]) == MY_Y)); // R4
endmodule

// File: tb/test_mesh_xy_router.sv
module test_mesh_xy_router;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] in_valid = '0, in_head = '0, in_tail = '0;
  logic [4:0][15:0] in_data = '0;
  logic [4:0] in_credit, out_valid, out_head, out_tail;
  logic [4:0][15:0] out_data;
  logic [4:0] auto_cr = '0, man_cr = '0, dn_cr;
  bit auto_ret = 1'b1;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [15:0] lg_d [5][32];
  logic        lg_h [5][32];
  logic        lg_t [5][32];
  int          lg_c [5][32];
  int          lg_n [5];
  int          cr_n [5];

  assign dn_cr = auto_cr | man_cr;

  mesh_xy_router i_mesh_xy_router (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_head(in_head), .in_tail(in_tail), .in_data(in_data),
    .in_credit(in_credit),
    .out_valid(out_valid), .out_head(out_head), .out_tail(out_tail), .out_data(out_data),
    .out_credit(dn_cr)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    for (int p = 0; p < 5; p++) begin lg_n[p] = 0; cr_n[p] = 0; end
    forever begin
      @(negedge clk);
      for (int p = 0; p < 5; p++) begin
        if (out_valid[p] === 1'b1 && lg_n[p] < 32) begin
          lg_d[p][lg_n[p]] = out_data[p];
          lg_h[p][lg_n[p]] = out_head[p];
          lg_t[p][lg_n[p]] = out_tail[p];
          lg_c[p][lg_n[p]] = cyc;
          lg_n[p]++;
        end
        if (in_credit[p] === 1'b1) cr_n[p]++;
      end
      auto_cr = auto_ret ? out_valid : '0;
    end
  end

  function automatic logic [15:0] mk(input logic [2:0] x, input logic [2:0] y, input logic [9:0] pl);
    return {pl, y, x};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(input int p, input bit h, input bit t, input logic [15:0] d);
    in_valid[p] = 1'b1; in_head[p] = h; in_tail[p] = t; in_data[p] = d;
  endtask

  task automatic tick();
    @(negedge clk);
    in_valid = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clear_logs();
    for (int p = 0; p < 5; p++) begin lg_n[p] = 0; cr_n[p] = 0; end
  endtask

  task automatic expect_flit(input int p, input int k, input bit h, input bit t,
                             input logic [15:0] d, input string req);
    if (lg_n[p] > k)
      chk(lg_d[p][k] === d && lg_h[p][k] === h && lg_t[p][k] === t, req, "flit",
          {14'd0, lg_h[p][k], lg_t[p][k], lg_d[p][k]}, {14'd0, h, t, d});
    else
      chk(1'b0, req, "missing flit", 32'(lg_n[p]), 32'(k + 1));
  endtask

  task automatic t_reset();
    chk(out_valid === 5'b0, "R1", "out_valid after reset", 32'(out_valid), 0);
    chk(in_credit === 5'b0, "R1", "in_credit after reset", 32'(in_credit), 0);
  endtask

  task automatic t_routing();
    clear_logs();
    put(0, 1, 1, mk(3, 6, 1)); tick(); idle(4);
    put(2, 1, 1, mk(0, 0, 2)); tick(); idle(4);
    put(3, 1, 1, mk(2, 7, 3)); tick(); idle(4);
    put(1, 1, 1, mk(2, 1, 4)); tick(); idle(4);
    put(4, 1, 1, mk(2, 2, 5)); tick(); idle(4);
    for (int p = 0; p < 5; p++) chk(lg_n[p] == 1, "R2", "one flit per exit", 32'(lg_n[p]), 1);
    expect_flit(2, 0, 1, 1, mk(3, 6, 1), "R2");
    expect_flit(4, 0, 1, 1, mk(0, 0, 2), "R2");
    expect_flit(1, 0, 1, 1, mk(2, 7, 3), "R3");
    expect_flit(3, 0, 1, 1, mk(2, 1, 4), "R3");
    expect_flit(0, 0, 1, 1, mk(2, 2, 5), "R4");
  endtask

  task automatic t_latency();
    clear_logs();
    put(4, 1, 1, mk(5, 1, 6));
    tick(); #1;
    chk(out_valid[2] === 1'b0, "R6", "early out_valid", 32'(out_valid[2]), 0);
    chk(in_credit[4] === 1'b0, "R8", "early credit", 32'(in_credit[4]), 0);
    @(negedge clk); #1;
    chk(out_valid[2] === 1'b1, "R6", "out_valid due", 32'(out_valid[2]), 1);
    chk(out_data[2] === mk(5, 1, 6) && out_head[2] === 1'b1 && out_tail[2] === 1'b1,
        "R6", "flit content", {14'd0, out_head[2], out_tail[2], out_data[2]}, {16'h3, mk(5, 1, 6)});
    chk(in_credit[4] === 1'b1, "R8", "credit pulse", 32'(in_credit[4]), 1);
    @(negedge clk); #1;
    chk(out_valid[2] === 1'b0, "R6", "single cycle out", 32'(out_valid[2]), 0);
    chk(in_credit[4] === 1'b0, "R8", "single cycle credit", 32'(in_credit[4]), 0);
    idle(2);
    chk(cr_n[4] == 1, "R8", "credit count", 32'(cr_n[4]), 1);
  endtask

  task automatic t_body_follows();
    clear_logs();
    put(0, 1, 0, mk(4, 2, 7)); tick();
    put(0, 0, 0, 16'h0000); tick();
    put(0, 0, 1, 16'h0038); tick();
    idle(6);
    chk(lg_n[2] == 3, "R5", "east count", 32'(lg_n[2]), 3);
    chk(lg_n[4] == 0, "R5", "west count", 32'(lg_n[4]), 0);
    expect_flit(2, 0, 1, 0, mk(4, 2, 7), "R5");
    expect_flit(2, 1, 0, 0, 16'h0000, "R5");
    expect_flit(2, 2, 0, 1, 16'h0038, "R5");
  endtask

  task automatic t_lock();
    clear_logs();
    put(4, 1, 0, mk(6, 2, 8)); tick();
    put(3, 1, 1, mk(5, 5, 9)); tick();
    put(4, 0, 0, 16'h1234); tick();
    put(4, 0, 1, 16'h5678); tick();
    idle(6);
    chk(lg_n[2] == 4, "R10", "east count", 32'(lg_n[2]), 4);
    expect_flit(2, 0, 1, 0, mk(6, 2, 8), "R10");
    expect_flit(2, 1, 0, 0, 16'h1234, "R10");
    expect_flit(2, 2, 0, 1, 16'h5678, "R10");
    expect_flit(2, 3, 1, 1, mk(5, 5, 9), "R10");
  endtask

  task automatic t_round_robin();
    clear_logs();
    put(0, 1, 1, mk(7, 0, 20));
    put(1, 1, 1, mk(7, 1, 21));
    put(3, 1, 1, mk(7, 3, 23));
    put(4, 1, 1, mk(7, 4, 24));
    tick(); idle(8);
    expect_flit(2, 0, 1, 1, mk(7, 4, 24), "R9");
    expect_flit(2, 1, 1, 1, mk(7, 0, 20), "R9");
    expect_flit(2, 2, 1, 1, mk(7, 1, 21), "R9");
    expect_flit(2, 3, 1, 1, mk(7, 3, 23), "R9");
    for (int k = 0; k < 3; k++)
      chk(lg_c[2][k+1] == lg_c[2][k] + 1, "R11", "back-to-back single flits",
          32'(lg_c[2][k+1] - lg_c[2][k]), 1);
  endtask

  task automatic t_credit_stall();
    clear_logs();
    auto_ret = 1'b0;
    idle(2);
    for (int k = 0; k < 6; k++) begin put(0, 1, 1, mk(2, 0, 10'(30 + k))); tick(); end
    idle(8);
    chk(lg_n[3] == 4, "R7", "sent before stall", 32'(lg_n[3]), 4);
    chk(cr_n[0] == 4, "R8", "credits tied to pops", 32'(cr_n[0]), 4);
    for (int k = 0; k < 4; k++) expect_flit(3, k, 1, 1, mk(2, 0, 10'(30 + k)), "R12");
    man_cr[3] = 1'b1; @(negedge clk); man_cr = '0;
    idle(5);
    chk(lg_n[3] == 5, "R7", "one flit per credit", 32'(lg_n[3]), 5);
    expect_flit(3, 4, 1, 1, mk(2, 0, 34), "R12");
    man_cr[3] = 1'b1; @(negedge clk); man_cr = '0;
    idle(5);
    chk(lg_n[3] == 6, "R7", "second credit", 32'(lg_n[3]), 6);
    expect_flit(3, 5, 1, 1, mk(2, 0, 35), "R12");
    chk(cr_n[0] == 6, "R8", "credit total", 32'(cr_n[0]), 6);
    man_cr[3] = 1'b1; repeat (4) @(negedge clk); man_cr = '0;
    auto_ret = 1'b1;
    idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    idle(2);
    t_routing();
    t_latency();
    t_body_follows();
    t_lock();
    t_round_robin();
    t_credit_stall();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule